// File: doc/BRIEF.md
# Peripheral Disable Wrapper

This block sits between a simple single-cycle register bus and a small set of peripheral instances. It holds one 8-bit disable register in which each bit belongs to one peripheral by position. A peripheral whose bit is set loses its clock, is held in reset, is cut off from the bus and has its digital outputs driven to zero. The effect is that an unused peripheral draws no dynamic power and cannot be reached by software until it is switched back on.

The bus address is split into a slot field and an offset field. Slot n (n below the peripheral count) addresses peripheral n, and the offset is forwarded unchanged to it. Slot 7, offset 0 is the disable register. When a bit is cleared, the peripheral's clock comes back first. Its reset stays asserted for one more cycle, so the peripheral sees one clock edge in reset and then starts from its reset values. The bus clock and any logic outside the peripherals are never gated.

Top module: `pmd_wrap`

## Requirements
- R1: A system reset (rst_n low) clears every bit of the disable register, and the register then reads 0x00.
- R2: A write to address slot 7 (bus_addr[4:2] = 7), offset 0 (bus_addr[1:0] = 0) loads all 8 bits of the disable register on that clock edge. A read of that address returns all 8 stored bits, including bits that have no peripheral.
- R3: Bit i of the disable register controls only peripheral i. It is selected by bus slot i (bus_addr[4:2] = i) and by lane i of every per-peripheral port.
- R4: While bit i is set, per_gclk[i] has no high phase. While bit i is clear, per_gclk[i] follows clk.
- R5: While bit i is set, per_rst_n[i] is low. per_rst_n[i] is also low whenever rst_n is low.
- R6: While bit i is set, a bus write to slot i does not assert per_wr[i], and the peripheral's registers stay unchanged.
- R7: While bit i is set, a bus read of slot i returns 0x00. An address that selects no peripheral and is not the disable register also reads 0x00, and bus_rdata is 0x00 whenever bus_sel is low.
- R8: While bit i is set, or while its reset is still held after re-enable, lane i of per_out is all zeros.
- R9: After bit i goes from 1 to 0, per_rst_n[i] stays low for exactly one more cycle while per_gclk[i] is running. The peripheral then reads back its reset values.
- R10: For an enabled peripheral, a bus access to slot i forwards the offset on per_addr, the data on per_wdata and a write strobe on per_wr[i]. A read returns that peripheral's read data. This holds regardless of the other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, never gated |
| rst_n | input | 1 | Asynchronous active-low system reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Slot in [4:2], offset in [1:0] |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| per_gclk | output | NP | Gated clock per peripheral |
| per_rst_n | output | NP | Active-low reset per peripheral |
| per_wr | output | NP | Write strobe per peripheral |
| per_addr | output | 2 | Register offset forwarded to peripherals |
| per_wdata | output | 8 | Write data forwarded to peripherals |
| per_rdata | input | NP*8 | Read data from each peripheral, lane i at [8i+7:8i] |
| per_out_raw | input | NP*OUT_W | Digital outputs from each peripheral |
| per_out | output | NP*OUT_W | Digital outputs after masking |

## Verification
Two functions can act in the same cycle. One is a peripheral changing its own output, the other is the disable register shutting it off or letting it out of reset. The bench writes a value into a peripheral register that drives its output, and in a later write sets that peripheral's disable bit. It then checks that the output lane drops to zero in the same cycle in which the disable register changes. On re-enable, it checks that the output stays zero through the held-reset cycle and then shows the reset value rather than the value written before. All of this is compared against a behavioural model on every cycle.

// File: rtl/pmd_pkg.sv
`timescale 1ns/1ps
package pmd_pkg;
  localparam int SLOT_W = 3;
  localparam int OFF_W  = 2;
  localparam int ADDR_W = SLOT_W + OFF_W;
  localparam int DATA_W = 8;

  typedef logic [SLOT_W-1:0] slot_t;
  typedef logic [OFF_W-1:0]  off_t;

  localparam slot_t CTRL_SLOT = slot_t'((1 << SLOT_W) - 1);
  localparam off_t  CTRL_OFF  = off_t'(0);

  function automatic slot_t slot_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction

  function automatic off_t off_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction

  // a lane is kept in reset while disabled and for the one cycle after
  function automatic logic lane_quiet(input logic dis, input logic hold);
    return dis | hold;
  endfunction
endpackage

// File: rtl/pmd_clk_gate.sv
`timescale 1ns/1ps
module pmd_clk_gate (
  input  logic clk,
  input  logic en,
  output logic gclk
);
  logic en_lat;

  // enable captured while clk is low, so gclk never glitches
  always_latch begin
    if (!clk) en_lat = en;
  end

  assign gclk = clk & en_lat;
endmodule

// File: rtl/pmd_ctrl_reg.sv
`timescale 1ns/1ps
module pmd_ctrl_reg #(
  parameter int DIS_W = 8,
  parameter int NP    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [DIS_W-1:0] wdata,
  output logic [DIS_W-1:0] dis_q,
  output logic [NP-1:0]    hold_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q  <= '0;
      hold_q <= '0;
    end else begin
      if (wr_hit) dis_q <= wdata;
      hold_q <= dis_q[NP-1:0];
    end
  end
endmodule

// File: rtl/pmd_lane.sv
`timescale 1ns/1ps
module pmd_lane import pmd_pkg::*; #(
  parameter int OUT_W = 8
) (
  input  logic              clk,
  input  logic              sys_rst_n,
  input  logic              dis,
  input  logic              hold,
  input  logic              acc_wr,
  input  logic              acc_rd,
  input  logic [DATA_W-1:0] rdata_in,
  input  logic [OUT_W-1:0]  out_raw,
  output logic              gclk,
  output logic              rst_n_o,
  output logic              wr_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [OUT_W-1:0]  out_o
);
  logic quiet;

  assign quiet = lane_quiet(dis, hold);

  pmd_clk_gate gate_i (
    .clk  (clk),
    .en   (~dis),
    .gclk (gclk)
  );

  assign rst_n_o = sys_rst_n & ~quiet;
  assign wr_o    = acc_wr & ~dis;
  assign rdata_o = (acc_rd && !dis) ? rdata_in : '0;
  assign out_o   = quiet ? '0 : out_raw;
endmodule

// File: rtl/pmd_wrap.sv
`timescale 1ns/1ps
module pmd_wrap import pmd_pkg::*; #(
  parameter int NP    = 4,
  parameter int OUT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [NP-1:0]       per_gclk,
  output logic [NP-1:0]       per_rst_n,
  output logic [NP-1:0]       per_wr,
  output logic [OFF_W-1:0]    per_addr,
  output logic [DATA_W-1:0]   per_wdata,
  input  logic [NP*DATA_W-1:0] per_rdata,
  input  logic [NP*OUT_W-1:0] per_out_raw,
  output logic [NP*OUT_W-1:0] per_out
);
  localparam int DIS_W = DATA_W;

  slot_t             slot;
  off_t              off;
  logic              ctrl_hit;
  logic              ctrl_wr;
  logic [DIS_W-1:0]  dis_q;
  logic [NP-1:0]     hold_q;
  logic [NP-1:0]     lane_hit;
  logic [DATA_W-1:0] lane_rd [NP];

  assign slot     = slot_of(bus_addr);
  assign off      = off_of(bus_addr);
  assign ctrl_hit = bus_sel && (slot == CTRL_SLOT) && (off == CTRL_OFF);
  assign ctrl_wr  = ctrl_hit && bus_wr;

  assign per_addr  = off;
  assign per_wdata = bus_wdata;

  pmd_ctrl_reg #(.DIS_W(DIS_W), .NP(NP)) ctrl_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_hit (ctrl_wr),
    .wdata  (bus_wdata),
    .dis_q  (dis_q),
    .hold_q (hold_q)
  );

  for (genvar g = 0; g < NP; g++) begin : g_lane
    assign lane_hit[g] = bus_sel && (slot == slot_t'(g));

    pmd_lane #(.OUT_W(OUT_W)) lane_i (
      .clk       (clk),
      .sys_rst_n (rst_n),
      .dis       (dis_q[g]),
      .hold      (hold_q[g]),
      .acc_wr    (lane_hit[g] && bus_wr),
      .acc_rd    (lane_hit[g]),
      .rdata_in  (per_rdata[g*DATA_W +: DATA_W]),
      .out_raw   (per_out_raw[g*OUT_W +: OUT_W]),
      .gclk      (per_gclk[g]),
      .rst_n_o   (per_rst_n[g]),
      .wr_o      (per_wr[g]),
      .rdata_o   (lane_rd[g]),
      .out_o     (per_out[g*OUT_W +: OUT_W])
    );
  end

  always_comb begin
    bus_rdata = ctrl_hit ? dis_q : '0;
    for (int i = 0; i < NP; i++) bus_rdata = bus_rdata | lane_rd[i];
  end
endmodule

// File: rtl/pmd_wrap_chk.sv
`timescale 1ns/1ps
module pmd_wrap_chk import pmd_pkg::*; #(
  parameter int NP    = 4,
  parameter int OUT_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_sel,
  input logic                bus_wr,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic [NP-1:0]       per_rst_n,
  input logic [NP-1:0]       per_wr,
  input logic [NP*OUT_W-1:0] per_out,
  input logic [DATA_W-1:0]   dis_q
);
  // R2: a control write lands on the next edge
  a_r2_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && slot_of(bus_addr) == CTRL_SLOT && off_of(bus_addr) == CTRL_OFF)
    |=> (dis_q == $past(bus_wdata)));

  for (genvar g = 0; g < NP; g++) begin : g_chk
    // R5
    a_r5_rst_held: assert property (@(posedge clk) disable iff (!rst_n)
      dis_q[g] |-> !per_rst_n[g]);
    // R6
    a_r6_wr_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      dis_q[g] |-> !per_wr[g]);
    // R7
    a_r7_rd_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && slot_of(bus_addr) == slot_t'(g) && dis_q[g]) |-> (bus_rdata == '0));
    // R8
    a_r8_out_zero: assert property (@(posedge clk) disable iff (!rst_n)
      dis_q[g] |-> (per_out[g*OUT_W +: OUT_W] == '0));
    // R9: held for the re-enable cycle, released after it
    a_r9_hold_one: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dis_q[g]) |-> !per_rst_n[g]);
    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dis_q[g]) |=> (dis_q[g] || per_rst_n[g]));
  end
endmodule

bind pmd_wrap pmd_wrap_chk #(.NP(NP), .OUT_W(OUT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .per_rst_n (per_rst_n),
  .per_wr    (per_wr),
  .per_out   (per_out),
  .dis_q     (dis_q)
);

// File: tb/pmd_wrap_tb_top.sv
`timescale 1ns/1ps
module pmd_stub #(
  parameter logic [7:0] BASE = 8'h10
) (
  input  logic       gclk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic [7:0] out
);
  logic [7:0] regs [4];
  always_ff @(posedge gclk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) regs[k] <= BASE + 8'(k);
    end else if (wr) begin
      regs[addr] <= wdata;
    end
  end
  assign rdata = regs[addr];
  assign out   = regs[0];
endmodule

module pmd_wrap_tb_top;
  localparam int NP = 4;
  localparam int OW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [NP-1:0] per_gclk, per_rst_n, per_wr;
  logic [1:0] per_addr;
  logic [7:0] per_wdata;
  logic [NP*8-1:0] per_rdata;
  logic [NP*OW-1:0] per_out_raw, per_out;

  always #5 clk = ~clk;

  pmd_wrap #(.NP(NP), .OUT_W(OW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .per_gclk(per_gclk), .per_rst_n(per_rst_n), .per_wr(per_wr),
    .per_addr(per_addr), .per_wdata(per_wdata), .per_rdata(per_rdata),
    .per_out_raw(per_out_raw), .per_out(per_out)
  );

  for (genvar g = 0; g < NP; g++) begin : g_stub
    pmd_stub #(.BASE(8'(16 * (g + 1)))) stub_i (
      .gclk(per_gclk[g]), .rst_n(per_rst_n[g]), .wr(per_wr[g]),
      .addr(per_addr), .wdata(per_wdata),
      .rdata(per_rdata[g*8 +: 8]), .out(per_out_raw[g*OW +: OW])
    );
  end

  // reference model
  logic [7:0]    m_dis;
  logic [NP-1:0] m_hold;
  logic [7:0]    m_regs [NP][4];
  int n_vec = 0, n_bad = 0;

  function automatic logic [7:0] rst_val(int p, int o);
    return 8'(16 * (p + 1) + o);
  endfunction

  task automatic m_reset_lane(int p);
    for (int k = 0; k < 4; k++) m_regs[p][k] = rst_val(p, k);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic s, input logic w, input logic [4:0] a,
                      input logic [7:0] d, input logic r);
    int sl, of;
    logic [7:0] e_rd;
    logic [NP-1:0] e_wr, e_rst, e_gclk, nh;
    @(negedge clk);
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d; rst_n = r;
    sl = int'(a[4:2]); of = int'(a[1:0]);
    if (!r) begin
      m_dis = '0; m_hold = '0;
      for (int p = 0; p < NP; p++) m_reset_lane(p);
    end
    #1;
    e_rd = '0;
    if (s) begin
      if (sl == 7 && of == 0) e_rd = m_dis;
      else if (sl < NP && !m_dis[sl]) e_rd = m_regs[sl][of];
    end
    chk(bus_rdata === e_rd, "R2/R7/R10 bus_rdata", bus_rdata, e_rd);
    for (int p = 0; p < NP; p++) begin
      e_wr[p]  = s && w && sl == p && !m_dis[p];
      e_rst[p] = r && !(m_dis[p] || m_hold[p]);
      chk(per_out[p*OW +: OW] === ((m_dis[p] || m_hold[p]) ? 8'h00 : m_regs[p][0]),
          "R8 per_out", per_out[p*OW +: OW], (m_dis[p] || m_hold[p]) ? 0 : m_regs[p][0]);
    end
    chk(per_wr === e_wr, "R6/R10 per_wr", per_wr, e_wr);
    chk(per_rst_n === e_rst, "R5/R9 per_rst_n", per_rst_n, e_rst);
    if (s) chk(per_addr === a[1:0], "R10 per_addr", per_addr, a[1:0]);
    e_gclk = ~m_dis[NP-1:0];
    if (r) begin
      if (s && w && sl < NP && !m_dis[sl] && !m_hold[sl]) m_regs[sl][of] = d;
      nh = m_dis[NP-1:0];
      if (s && w && sl == 7 && of == 0) m_dis = d;
      m_hold = nh;
      for (int p = 0; p < NP; p++) if (m_dis[p] || m_hold[p]) m_reset_lane(p);
    end
    @(posedge clk); #1;
    chk(per_gclk === e_gclk, "R4 per_gclk", per_gclk, e_gclk);
  endtask

  task automatic wr(input int sl, input int of, input logic [7:0] d);
    step(1'b1, 1'b1, {3'(sl), 2'(of)}, d, 1'b1);
  endtask
  task automatic rd(input int sl, input int of);
    step(1'b1, 1'b0, {3'(sl), 2'(of)}, 8'h00, 1'b1);
  endtask
  task automatic idle();
    step(1'b0, 1'b0, 5'd0, 8'h00, 1'b1);
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] lf;
    step(1'b0, 1'b0, 5'd0, 8'h00, 1'b0);
    step(1'b0, 1'b0, 5'd0, 8'h00, 1'b0);
    // R1: register reads zero after reset
    rd(7, 0);
    // R10: normal access on every lane
    for (int p = 0; p < NP; p++) begin
      rd(p, 1);
      wr(p, 2, 8'(8'hC0 + p));
      rd(p, 2);
    end
    // R2, R3: disable lanes 0 and 2, plus unused bits 5 and 7
    wr(7, 0, 8'hA5);
    rd(7, 0);
    // R7, R6: disabled lane reads zero, write dropped
    rd(0, 2);
    wr(0, 0, 8'h77);
    rd(2, 1);
    // R10: enabled lane unaffected by others
    rd(1, 2);
    wr(3, 1, 8'h5A);
    rd(3, 1);
    // unmapped slot reads zero (R7)
    rd(5, 0);
    // R9: re-enable lane 0 keeps other bits
    wr(7, 0, 8'hA4);
    rd(0, 0);
    rd(0, 2);
    rd(7, 0);
    // R8: output of lane 3 switched off by its disable bit
    wr(3, 0, 8'h3C);
    idle();
    wr(7, 0, 8'hAC);
    idle();
    wr(7, 0, 8'h00);
    idle();
    idle();
    rd(3, 0);
    // mixed traffic
    lf = 8'h1D;
    for (int n = 0; n < 60; n++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      if (lf[2:0] == 3'd7) wr(7, 0, {4'h0, lf[6:3]});
      else if (lf[0]) wr(int'(lf[5:4]), int'(lf[7:6]), lf ^ 8'h96);
      else rd(int'(lf[5:4]), int'(lf[7:6]));
    end
    // R1: system reset mid-run clears disable bits
    wr(7, 0, 8'hFF);
    step(1'b0, 1'b0, 5'd0, 8'h00, 1'b0);
    rd(7, 0);
    rd(2, 3);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule